// File: doc/BRIEF.md
# Two-Step Channel Interleaver Address Generator

This block produces, one per clock, the permuted addresses a block channel interleaver needs to move an OFDM coded block between its write order and its read order. Each block of N coded bits is first spread column-wise across d columns, so that neighbouring bits land on distant subcarriers. A second step then rotates bits inside small groups of size s, so that neighbouring bits alternate between the more and the less reliable bit positions of a constellation. Both steps are computed from counters and a little modular arithmetic. No permutation table is stored.

A controller sets the block size, the column count (given as a base-2 logarithm), the bits per subcarrier and the direction, then pulses start. The block then emits N addresses on a valid/ready stream and marks the final one. The stream follows these rules: an address is transferred on a clock edge where both valid and ready are high. While valid is high and ready is low, the address and the last flag hold. Valid never depends on ready. In the reverse (de-interleave) direction the block emits the inverse permutation. A memory can then put received bits back into their original order.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, busy, addr_valid and addr_last are low.
- R2: A start pulse seen while idle latches cfg_size, cfg_col_lg, cfg_bpsc and cfg_deint. From the next clock, busy and addr_valid are high with the address for index 0.
- R3: With cfg_deint = 0, for d = 2^cfg_col_lg and R = N/d, the address for index k is j = s·floor(m/s) + ((m + N − floor(d·m/N)) mod s), where m = R·(k mod d) + floor(k/d).
- R4: With cfg_deint = 1, the address emitted at position i is the index k whose R3 address equals i. The two runs are exact inverses.
- R5: One run emits exactly N addresses. Each is below N, and together they form a full permutation of 0..N−1.
- R6: addr_last is high on the N-th address only. After that address is accepted, addr_valid and busy fall at the next clock.
- R7: While addr_valid is high and addr_ready is low, addr_data and addr_last hold. The index advances only on an accepted transfer.
- R8: A start pulse or configuration change during a run has no effect on the addresses of that run.
- R9: The group size s is derived from cfg_bpsc: 6 gives 3, 4 gives 2, and 1 or 2 give 1. With s = 1 the second step is the identity, so the address equals m.
- R10: The configuration must satisfy two conditions: N is a multiple of d, and R is a multiple of s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| cfg_size | input | N_W | Block size N |
| cfg_col_lg | input | 3 | Base-2 logarithm of the column count d |
| cfg_bpsc | input | 3 | Coded bits per subcarrier: 1, 2, 4 or 6 |
| cfg_deint | input | 1 | 1 selects the inverse permutation |
| busy | output | 1 | A run is in progress |
| addr_valid | output | 1 | addr_data holds a valid address |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_data | output | N_W | Permuted address |
| addr_last | output | 1 | Final address of the block |

## Verification
A fault in the row/column counters or in the column accumulator shows up on the first address that uses the faulty value. In practice this is within d transfers of the start, because the column wraps that often. A wrong residue in the group rotation changes the address only inside an s-sized group. It therefore appears within s transfers once s exceeds 1, while runs with s = 1 stay unaffected. A wrong end-of-block compare shows as a missing or misplaced last flag, or as a duplicate or out-of-range address. The full-permutation check over each run exposes such errors at the end of that run at the latest.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;

  // Group size of the second permutation step, from coded bits per subcarrier.
  function automatic logic [1:0] grp_from_bpsc(input logic [2:0] bpsc);
    case (bpsc)
      3'd6:    return 2'd3;
      3'd4:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Residue of x modulo a group size of 1, 2 or 3.
  function automatic logic [1:0] mod_grp(input logic [15:0] x, input logic [1:0] g);
    case (g)
      2'd2:    return {1'b0, x[0]};
      2'd3:    return 2'(x % 16'd3);
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ilv_idx_cnt.sv
// Two-level index counter: lo is the fast digit wrapping at lo_lim, hi the
// slow digit. acc accumulates acc_inc on the fast digit (forward) or on the
// slow digit (reverse), so no multiplier is needed.
module ilv_idx_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         deint,
  input  logic [W-1:0] lo_lim,
  input  logic [W-1:0] hi_lim,
  input  logic [W-1:0] acc_inc,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic [W-1:0] acc,
  output logic         at_end
);

  logic wrap;
  assign wrap   = (lo == lo_lim);
  assign at_end = wrap && (hi == hi_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo  <= '0;
      hi  <= '0;
      acc <= '0;
    end else if (step) begin
      if (wrap) begin
        lo  <= '0;
        hi  <= hi + 1'b1;
        acc <= deint ? acc + acc_inc : '0;
      end else begin
        lo <= lo + 1'b1;
        if (!deint) acc <= acc + acc_inc;
      end
    end
  end

  // The fast digit never runs past its limit while stepping.
  assert_lo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (lo <= lo_lim));

endmodule

// File: rtl/ilv_perm.sv
// Combinational address mapping from the counter digits.
// Forward: m = acc + hi, and floor(d*m/N) equals the column digit lo.
// Reverse: i = acc + lo, and floor(d*i/N) equals the block digit hi.
module ilv_perm #(
  parameter int W = 12
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] acc,
  input  logic [2:0]   col_lg,
  input  logic [1:0]   grp,
  input  logic [1:0]   n_res,
  input  logic         deint,
  output logic [W-1:0] addr
);
  import ilv_pkg::*;

  logic [W-1:0] m_f, i_r, lo_r, addr_f, addr_r;
  logic [1:0]   t_f, c_f, v_f, t_r, h_r, u_r;

  always_comb begin
    // forward direction
    m_f    = acc + hi;
    t_f    = mod_grp(16'(m_f), grp);
    c_f    = mod_grp(16'(lo), grp);
    v_f    = mod_grp(16'(t_f) + 16'(n_res) + 16'(grp) - 16'(c_f), grp);
    addr_f = m_f - W'(t_f) + W'(v_f);
    // reverse direction
    i_r    = acc + lo;
    t_r    = mod_grp(16'(i_r), grp);
    h_r    = mod_grp(16'(hi), grp);
    u_r    = mod_grp(16'(t_r) + 16'(h_r), grp);
    lo_r   = lo + W'(u_r) - W'(t_r);
    addr_r = (lo_r << col_lg) + hi;
    addr   = deint ? addr_r : addr_f;
  end

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
  parameter int N_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] cfg_size,
  input  logic [2:0]     cfg_col_lg,
  input  logic [2:0]     cfg_bpsc,
  input  logic           cfg_deint,
  output logic           busy,
  output logic           addr_valid,
  input  logic           addr_ready,
  output logic [N_W-1:0] addr_data,
  output logic           addr_last
);
  import ilv_pkg::*;

  run_st_e        st;
  logic [N_W-1:0] n_q, rows_q;
  logic [2:0]     lg_q;
  logic [1:0]     grp_q, nres_q;
  logic           deint_q;

  logic [N_W-1:0] d_val, lo_lim, hi_lim, lo, hi, acc;
  logic           at_end, clear, step;
  logic [1:0]     grp_in;

  assign grp_in = grp_from_bpsc(cfg_bpsc);
  assign clear  = (st == ST_IDLE) && start;
  assign step   = (st == ST_RUN) && addr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      n_q     <= '0;
      rows_q  <= '0;
      lg_q    <= '0;
      grp_q   <= 2'd1;
      nres_q  <= '0;
      deint_q <= 1'b0;
    end else if (clear) begin
      st      <= ST_RUN;
      n_q     <= cfg_size;
      rows_q  <= cfg_size >> cfg_col_lg;
      lg_q    <= cfg_col_lg;
      grp_q   <= grp_in;
      nres_q  <= mod_grp(16'(cfg_size), grp_in);
      deint_q <= cfg_deint;
    end else if (step && at_end) begin
      st <= ST_IDLE;
    end
  end

  assign d_val  = N_W'(1) << lg_q;
  assign lo_lim = deint_q ? rows_q - 1'b1 : d_val - 1'b1;
  assign hi_lim = deint_q ? d_val - 1'b1 : rows_q - 1'b1;

  ilv_idx_cnt #(.W(N_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step), .deint(deint_q),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .acc_inc(rows_q),
    .lo(lo), .hi(hi), .acc(acc), .at_end(at_end)
  );

  ilv_perm #(.W(N_W)) u_perm (
    .lo(lo), .hi(hi), .acc(acc), .col_lg(lg_q), .grp(grp_q),
    .n_res(nres_q), .deint(deint_q), .addr(addr_data)
  );

  assign busy       = (st == ST_RUN);
  assign addr_valid = busy;
  assign addr_last  = busy && at_end;

  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr_data < n_q));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_data) && $stable(addr_last)));
  assert_drop_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && addr_last) |=> !addr_valid);
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(n_q) && $stable(grp_q) && $stable(deint_q)));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> addr_valid);

endmodule

// File: tb/ilv_addr_gen_bench.sv
`timescale 1ns/1ps
module ilv_addr_gen_bench;
  localparam int N_W = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N_W-1:0] cfg_size = '0;
  logic [2:0]     cfg_col_lg = '0;
  logic [2:0]     cfg_bpsc = 3'd1;
  logic           cfg_deint = 1'b0;
  logic           busy, addr_valid, addr_last;
  logic           addr_ready = 1'b0;
  logic [N_W-1:0] addr_data;

  int n_chk = 0;
  int n_fail = 0;
  int pm [1024];
  int ex [1024];
  bit seen [1024];

  always #4 clk = ~clk;

  ilv_addr_gen #(.N_W(N_W)) u_ilv_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_size(cfg_size),
    .cfg_col_lg(cfg_col_lg), .cfg_bpsc(cfg_bpsc), .cfg_deint(cfg_deint),
    .busy(busy), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_data(addr_data), .addr_last(addr_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference of both formulas, straight from the requirements.
  task automatic build_model(input int n, input int lg, input int bpsc, input bit deint);
    int d, s;
    d = 1 << lg;
    s = (bpsc == 6) ? 3 : (bpsc == 4) ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      int m;
      m = (n / d) * (k % d) + k / d;
      pm[k] = s * (m / s) + ((m + n - (d * m) / n) % s);
    end
    for (int k = 0; k < n; k++) begin
      if (deint) ex[pm[k]] = k;
      else       ex[k] = pm[k];
    end
  endtask

  task automatic run(input int n, input int lg, input int bpsc, input bit deint,
                     input int stall, input bit poke, input string tag);
    int idx, guard, cyc, lasts;
    build_model(n, lg, bpsc, deint);
    for (int k = 0; k < 1024; k++) seen[k] = 1'b0;
    @(negedge clk);
    cfg_size = N_W'(n); cfg_col_lg = 3'(lg); cfg_bpsc = 3'(bpsc); cfg_deint = deint;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(addr_valid === 1'b1 && busy === 1'b1, "R2 valid after start", int'(addr_valid), 1);
    idx = 0; guard = 0; cyc = 0; lasts = 0;
    while (idx < n && guard < 20000) begin
      bit rdy;
      if (poke && idx == 5) begin
        start = 1'b1; cfg_size = N_W'(n / 2); cfg_bpsc = 3'd1; cfg_deint = ~deint;
      end else begin
        start = 1'b0;
      end
      if (!addr_valid) begin
        chk(1'b0, "R5 valid dropped early", idx, n);
        break;
      end
      rdy = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      chk(int'(addr_data) == ex[idx], rdy ? tag : "R7 held address", int'(addr_data), ex[idx]);
      if (addr_last !== (idx == n - 1))
        chk(1'b0, "R6 last flag", int'(addr_last), int'(idx == n - 1));
      addr_ready = rdy;
      if (rdy) begin
        if (addr_data < N_W'(n)) seen[addr_data] = 1'b1;
        if (addr_last) lasts++;
        idx++;
      end
      cyc++; guard++;
      @(negedge clk);
    end
    start = 1'b0;
    addr_ready = 1'b0;
    chk(addr_valid === 1'b0 && busy === 1'b0, "R6 idle after last", int'(addr_valid), 0);
    chk(lasts == 1, "R6 one last flag", lasts, 1);
    begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < n; k++) if (seen[k]) cnt++;
      chk(cnt == n && idx == n, "R5 full permutation", cnt, n);
    end
    if (poke) chk(idx == n, "R8 run unaffected by start", idx, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && addr_valid === 1'b0 && addr_last === 1'b0, "R1 reset state",
        int'(addr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_valid === 1'b0, "R1 idle after reset", int'(addr_valid), 0);
    run(48,  4, 1, 1'b0, 0, 1'b0, "R9 bpsc1 identity second step");
    run(96,  4, 2, 1'b0, 0, 1'b0, "R9 bpsc2 identity second step");
    run(192, 4, 4, 1'b0, 0, 1'b0, "R3 s=2 forward");
    run(288, 4, 6, 1'b0, 3, 1'b0, "R3 s=3 forward with stalls");
    run(48,  3, 6, 1'b0, 0, 1'b0, "R3 d=8 s=3 forward R10");
    run(384, 4, 6, 1'b0, 0, 1'b1, "R3 large block with start poke");
    run(288, 4, 6, 1'b1, 0, 1'b0, "R4 s=3 inverse");
    run(192, 4, 4, 1'b1, 2, 1'b0, "R4 s=2 inverse with stalls");
    run(96,  4, 2, 1'b1, 0, 1'b1, "R4 s=1 inverse with start poke");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule